// File: doc/BRIEF.md
# Framed Serial Display Data Receiver

This block is the input stage of a display driver. It listens, receive-only, to a two-line serial bus made of a clock line and a data line, both of which rest high. A falling data line while the clock is high opens a transaction. A rising data line while the clock is high closes it. Each line is resynchronised into the system clock domain before any edge or condition is judged.

After an opening condition, the first eight bits form an address, sent most significant bit first. If the address equals the block's own, the bits that follow are shifted into a 128-bit shift register. That register is copied into a display latch in one of two ways. The first is automatic: while the enable input is high, a copy is made after each group of 128 bits. The second is manual: while enable is low, the automatic copy is suppressed, and a rising enable while the clock is high makes the copy. Between groups, one clock rise is consumed as a gap. This lets a host stream group after group without sending a new address.

The latched word and a one-cycle strobe that marks each load are the only outputs.

Top module: `serial_display_rx`

## Requirements
- R1: After reset the receiver is idle and unaddressed, the bit counter is zero, `disp_word` is all zeros and `disp_load` is low.
- R2: A start is recognised when the synchronised data line falls while the synchronised clock line stays high. It begins an address phase from any state.
- R3: A stop is recognised when the synchronised data line rises while the synchronised clock line stays high. It returns the receiver to idle from any state.
- R4: The eight bits that follow a start are taken on rising clock edges, most significant bit first, and compared with parameter `DEV_ADDR`. On a mismatch, every later clock edge is ignored until the next start.
- R5: In an addressed transfer, data is sampled on rising clock edges and shifted in toward the least significant end. The first bit of a 128-bit group therefore ends up in `disp_word[127]` and the last bit in `disp_word[0]`.
- R6: While `en_in` is high, the register is copied into `disp_word` in the cycle after the 128th bit of each group is sampled, and `disp_load` is high for exactly that one cycle.
- R7: While `en_in` is low, no copy is made at the end of a group. A rising `en_in` while the clock line is high copies the current shift register into `disp_word` and pulses `disp_load`.
- R8: If neither a start nor a stop follows a 128-bit group, the next rising clock edge is ignored. The edge after it carries the first bit of the next group.
- R9: A stop in the middle of a group abandons the transfer. Clock edges after it shift nothing until a start and a matching address arrive. The bit count of the new transfer starts again at zero.
- R10: A start that arrives without a preceding stop restarts the address phase and clears the bit count.
- R11: When the rise of `en_in` and the sampling of a group's 128th bit fall in the same system cycle, exactly one load happens, and the loaded word includes that 128th bit.
- R12: `disp_word` changes only in a cycle in which `disp_load` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line, idle high, asynchronous |
| sda_in | input | 1 | Serial data line, idle high, asynchronous |
| en_in | input | 1 | Latch enable: high selects automatic copies; a rise while the clock is high forces a copy |
| disp_word | output | DATA_BITS | Latched display word |
| disp_load | output | 1 | One-cycle strobe in the cycle `disp_word` is loaded |

## Verification
Two functions can land in the same system cycle: the automatic copy at the 128th clock rise, and the manual copy requested by an enable rise. The bench provokes the collision by holding enable low through 127 bits. It then drives the clock line and `en_in` high on the same edge, so that both signals cross matching synchronisers together. The result is judged by counting load strobes, which must grow by exactly one, and by comparing the latched word with the full group including its final bit.

// File: rtl/disp_rx_pkg.sv
package disp_rx_pkg;

    localparam int ADDR_BITS = 8;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_ADDR = 2'd1,
        RX_DATA = 2'd2,
        RX_SKIP = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic clk_rise;
        logic start;
        logic stop;
        logic en_rise;
        logic en_high;
        logic dat;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [ADDR_BITS-1:0] got,
                                      input logic [ADDR_BITS-1:0] own);
        return got == own;
    endfunction

endpackage

// File: rtl/bus_sync_detect.sv
module bus_sync_detect
    import disp_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    input  logic    en_in,
    output bus_ev_t ev
);
    localparam int STAGES = 2;

    logic [STAGES-1:0] scl_m, sda_m, en_m;
    logic scl_q, sda_q, en_q;
    logic scl_s, sda_s, en_s;

    // Flops reset high, which is the idle level, so leaving reset cannot
    // look like a condition or an enable edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_m <= '1;
            sda_m <= '1;
            en_m  <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            en_q  <= 1'b1;
        end else begin
            scl_m <= {scl_m[STAGES-2:0], scl_in};
            sda_m <= {sda_m[STAGES-2:0], sda_in};
            en_m  <= {en_m[STAGES-2:0], en_in};
            scl_q <= scl_m[STAGES-1];
            sda_q <= sda_m[STAGES-1];
            en_q  <= en_m[STAGES-1];
        end
    end

    assign scl_s = scl_m[STAGES-1];
    assign sda_s = sda_m[STAGES-1];
    assign en_s  = en_m[STAGES-1];

    always_comb begin
        ev.clk_rise = scl_s & ~scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.en_rise  = en_s & ~en_q & scl_s;
        ev.en_high  = en_s;
        ev.dat      = sda_s;
    end

endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
    import disp_rx_pkg::*;
#(
    parameter int                   DATA_BITS = 128,
    parameter logic [ADDR_BITS-1:0] DEV_ADDR  = 8'h5C
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    output logic    shift_en,
    output logic    block_done
);
    localparam int CW = $clog2(DATA_BITS);
    localparam logic [CW-1:0] LAST_DATA = CW'(DATA_BITS - 1);
    localparam logic [CW-1:0] LAST_ADDR = CW'(ADDR_BITS - 1);

    rx_state_e            state;
    logic [CW-1:0]        cnt;
    logic [ADDR_BITS-2:0] addr_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            addr_sr <= '0;
        end else if (ev.start) begin
            state <= RX_ADDR;
            cnt   <= '0;
        end else if (ev.stop) begin
            state <= RX_IDLE;
            cnt   <= '0;
        end else if (ev.clk_rise) begin
            unique case (state)
                RX_IDLE: ;
                RX_ADDR: begin
                    addr_sr <= {addr_sr[ADDR_BITS-3:0], ev.dat};
                    if (cnt == LAST_ADDR) begin
                        cnt   <= '0;
                        state <= addr_hit({addr_sr, ev.dat}, DEV_ADDR) ? RX_DATA : RX_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == LAST_DATA) begin
                        cnt   <= '0;
                        state <= RX_SKIP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_SKIP: state <= RX_DATA;
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign shift_en   = (state == RX_DATA) && ev.clk_rise;
    assign block_done = shift_en && (cnt == LAST_DATA);

    assert_stop_idle_R3: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (state == RX_IDLE));

    assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == RX_ADDR && cnt == '0));

    assert_gap_edge_R8: assert property (@(posedge clk) disable iff (rst)
        (state == RX_SKIP && ev.clk_rise) |=> (state == RX_DATA && cnt == '0));

    assert_unaddressed_R4: assert property (@(posedge clk) disable iff (rst)
        (state == RX_IDLE && !ev.start) |=> (state == RX_IDLE));

endmodule

// File: rtl/shift_latch.sv
module shift_latch #(
    parameter int DATA_BITS = 128
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift_en,
    input  logic                 bit_in,
    input  logic                 block_done,
    input  logic                 en_high,
    input  logic                 en_rise,
    output logic [DATA_BITS-1:0] word,
    output logic                 load
);
    logic [DATA_BITS-1:0] sr;
    logic [DATA_BITS-1:0] sr_next;
    logic                 auto_take;

    assign sr_next   = {sr[DATA_BITS-2:0], bit_in};
    assign auto_take = block_done && en_high;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '0;
            word <= '0;
            load <= 1'b0;
        end else begin
            load <= 1'b0;
            if (shift_en) sr <= sr_next;
            // The group-end copy wins over a coincident enable rise, so the
            // final bit is never dropped.
            if (auto_take) begin
                word <= sr_next;
                load <= 1'b1;
            end else if (en_rise) begin
                word <= sr;
                load <= 1'b1;
            end
        end
    end

    assert_auto_latch_R6: assert property (@(posedge clk) disable iff (rst)
        (block_done && en_high) |=> load);

    assert_auto_off_R7: assert property (@(posedge clk) disable iff (rst)
        (block_done && !en_high) |=> !load);

    assert_last_bit_kept_R11: assert property (@(posedge clk) disable iff (rst)
        (block_done && en_rise) |=> (load && word[0] == $past(bit_in)));

endmodule

// File: rtl/serial_display_rx.sv
module serial_display_rx
    import disp_rx_pkg::*;
#(
    parameter int                   DATA_BITS = 128,
    parameter logic [ADDR_BITS-1:0] DEV_ADDR  = 8'h5C
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_in,
    input  logic                 sda_in,
    input  logic                 en_in,
    output logic [DATA_BITS-1:0] disp_word,
    output logic                 disp_load
);
    bus_ev_t ev;
    logic    shift_en;
    logic    block_done;

    bus_sync_detect u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .en_in  (en_in),
        .ev     (ev)
    );

    frame_ctrl #(
        .DATA_BITS (DATA_BITS),
        .DEV_ADDR  (DEV_ADDR)
    ) u_frame (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .shift_en   (shift_en),
        .block_done (block_done)
    );

    shift_latch #(
        .DATA_BITS (DATA_BITS)
    ) u_latch (
        .clk        (clk),
        .rst        (rst),
        .shift_en   (shift_en),
        .bit_in     (ev.dat),
        .block_done (block_done),
        .en_high    (ev.en_high),
        .en_rise    (ev.en_rise),
        .word       (disp_word),
        .load       (disp_load)
    );

    assert_word_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !disp_load |-> $stable(disp_word));

endmodule

// File: tb/sim_serial_display_rx.sv
`timescale 1ns/1ps
module sim_serial_display_rx;
    localparam int         W   = 128;
    localparam logic [7:0] DEV = 8'h5C;
    localparam int         HP  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1, sda = 1'b1, en = 1'b1;
    logic [W-1:0] disp_word;
    logic         disp_load;
    int nchk = 0, nerr = 0, nload = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serial_display_rx u0 (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda), .en_in(en),
        .disp_word(disp_word), .disp_load(disp_load)
    );

    always @(negedge clk) if (!rst && disp_load) nload++;

    function automatic logic [W-1:0] rand_block();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [7:0] wrong_addr(input int k);
        return DEV ^ (8'h01 << (k % 8));
    endfunction

    task automatic phase(); repeat (HP) @(negedge clk); endtask

    task automatic chk_w(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: word act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_i(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_start();
        if (!scl) begin sda = 1'b1; phase(); scl = 1'b1; phase(); end
        sda = 1'b0; phase(); scl = 1'b0; phase();
    endtask

    task automatic do_stop();
        sda = 1'b0; phase(); scl = 1'b1; phase(); sda = 1'b1; phase();
    endtask

    task automatic send_bit(input logic b);
        sda = b; phase(); scl = 1'b1; phase(); scl = 1'b0; phase();
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_block(input logic [W-1:0] v, input int nbits);
        for (int i = W - 1; i >= W - nbits; i--) send_bit(v[i]);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] a, b, c, last;
        int base;
        void'($urandom(32'h1D5A_0C33));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        phase();
        // R1 reset state
        chk_w("R1", disp_word, '0);
        chk_i("R1 strobe", nload, 0);

        // R5 R6 R8: two groups back to back with one ignored edge between
        a = rand_block(); b = rand_block();
        base = nload;
        do_start(); send_byte(DEV); send_block(a, W); phase();
        chk_w("R5/R6 first group", disp_word, a);
        chk_i("R6 one strobe", nload, base + 1);
        send_bit(~b[W-1]);                 // gap edge, must be ignored (R8)
        send_block(b, W); phase();
        chk_w("R8 group after gap", disp_word, b);
        chk_i("R8 strobes", nload, base + 2);
        do_stop();
        last = b;

        // R4 mismatched address is ignored
        base = nload;
        do_start(); send_byte(wrong_addr(3)); send_block(rand_block(), W); phase();
        chk_w("R4 mismatch word", disp_word, last);
        chk_i("R4 mismatch strobe", nload, base);
        do_stop();

        // R7 enable low suppresses, enable rise loads
        en = 1'b0; a = rand_block(); base = nload;
        do_start(); send_byte(DEV); send_block(a, W); phase();
        chk_w("R7 suppressed word", disp_word, last);
        chk_i("R7 suppressed strobe", nload, base);
        do_stop();
        en = 1'b1; phase(); phase();
        chk_w("R7 manual load", disp_word, a);
        chk_i("R7 manual strobe", nload, base + 1);
        last = a;

        // R9 stop mid-group, orphan clocks, then a fresh transfer
        base = nload;
        do_start(); send_byte(DEV); send_block(rand_block(), 50); do_stop();
        scl = 1'b0; phase();
        send_block(rand_block(), W); phase();
        chk_i("R9 orphan clocks strobe", nload, base);
        chk_w("R9 orphan clocks word", disp_word, last);
        c = rand_block();
        do_start(); send_byte(DEV); send_block(c, W); phase();
        chk_w("R9 fresh transfer", disp_word, c);
        chk_i("R9 fresh strobe", nload, base + 1);
        do_stop();

        // R10 repeated start without stop; R2 start from mid-transfer
        base = nload; c = rand_block();
        do_start(); send_byte(DEV); send_block(rand_block(), 30);
        do_start(); send_byte(DEV); send_block(c, W); phase();
        chk_w("R10 restart word", disp_word, c);
        chk_i("R10/R2 restart strobe", nload, base + 1);
        do_stop();

        // R11 enable rise coincides with the 128th edge
        en = 1'b0; base = nload; c = rand_block();
        do_start(); send_byte(DEV); send_block(c, W - 1);
        sda = c[0]; phase();
        scl = 1'b1; en = 1'b1; phase(); phase();
        chk_w("R11 coincident word", disp_word, c);
        chk_i("R11 single strobe", nload, base + 1);
        scl = 1'b0; phase();
        do_stop();
        last = c;

        // R3 R4 R12 random transfers, mixed matching and foreign addresses
        for (int t = 0; t < 8; t++) begin
            logic hit;
            hit = $urandom_range(0, 1) == 1;
            c = rand_block(); base = nload;
            do_start();
            send_byte(hit ? DEV : wrong_addr($urandom_range(0, 7)));
            send_block(c, W); phase();
            if (hit) last = c;
            chk_w("R4/R12 random word", disp_word, last);
            chk_i("R3/R6 random strobe", nload, base + (hit ? 1 : 0));
            do_stop();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule